// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's complement operands of width `W` and returns the full signed product of width `2W`. It works on one multiplier bit per clock with radix-2 Booth recoding. An accumulator, the multiplier register and one extra low bit form a single chain that shifts right once per step. The two lowest bits of that chain choose whether the multiplicand is added to the accumulator, subtracted from it, or left out before the shift.

A caller drives `start` high for one cycle with both operands while the block is idle. The block then raises `busy`, runs exactly `W` steps, and pulses `done` for one cycle. From that cycle on, `product` holds the result until the next accepted `start`. Negative operands need no sign correction afterwards, because the recoding and the arithmetic shift handle both signs in the same way.

Top module: `booth_seq_mul`

## Requirements
- R1: A `start` high at a clock edge while `busy` is low is accepted. In the next cycle `busy` is 1 and `product` is `{W zeros, multiplier operand}`: the accumulator and the extra low bit are cleared, and the multiplicand is captured.
- R2: `done` goes high exactly `W` clock cycles after the edge that accepted `start`. `busy` stays high for the `W` cycles between these two edges.
- R3: `done` is high for a single cycle per operation.
- R4: When `done` is high, `product` equals the signed product of `mcand` and `mplier`, both read as two's complement `W`-bit values. For each step the low bit pair (Q0, extra bit) selects the action: 10 subtracts the multiplicand, 01 adds it, and 00 or 11 only shifts.
- R5: The product is exact when either operand, or both, is the most negative value -2^(W-1). In particular, (-2^(W-1))·(-2^(W-1)) = +2^(2W-2).
- R6: A `start` pulse while `busy` is high is ignored. It neither changes the running result nor the number of cycles the operation takes.
- R7: `busy` and `done` are never high in the same cycle.
- R8: After reset, `busy`, `done` and `product` are all 0.
- R9: While idle and without `start`, `product` keeps its value.
- R10: Each step shifts arithmetically: the accumulator's sign bit is copied into the top bit as the accumulator, multiplier and extra bit move right by one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; takes effect only when idle |
| mcand | input | W | Multiplicand, signed |
| mplier | input | W | Multiplier, signed |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2W | Signed product `{accumulator, multiplier register}` |

## Verification
The bench builds two copies of the block. One has `W=4`, and every one of its 256 operand pairs is run, so each pattern of recoded runs is covered, including the cases that push the accumulator to its widest excursion. The other has `W=8` and is fed random pairs from a fixed seed, plus directed extreme values and a `start` pulse issued mid-operation. These cover the accumulator guard bit at -128·-128 and check that the cycle count stays at eight.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    acc;
  logic [W:0]    mext;
  logic [W-1:0]  qreg;
  logic          qm1;
  logic [CW-1:0] steps;
  logic [W:0]    sum;

  always_comb begin
    case ({qreg[0], qm1})
      2'b10:   sum = acc - mext;
      2'b01:   sum = acc + mext;
      default: sum = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      mext  <= '0;
      qreg  <= '0;
      qm1   <= 1'b0;
      steps <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc   <= {sum[W], sum[W:1]};
        qreg  <= {sum[0], qreg[W-1:1]};
        qm1   <= qreg[0];
        steps <= steps - 1'b1;
        if (steps == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        acc   <= '0;
        mext  <= {mcand[W-1], mcand};
        qreg  <= mplier;
        qm1   <= 1'b0;
        steps <= CW'(W);
        busy  <= 1'b1;
      end
    end
  end

  assign product = {acc[W-1:0], qreg};

  logic [CW:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy)           lat_cnt <= lat_cnt + 1'b1;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == {{W{1'b0}}, $past(mplier)}));
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == (CW+1)'(W)));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mext));
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_arith_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (acc[W] == acc[W-1] || acc[W] == $past(acc[W])));
endmodule

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        st8 = 1'b0, st4 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy8, done8, busy4, done4;
  logic [15:0] p8;
  logic [7:0]  p4;

  booth_seq_mul #(.W(8)) dut_i (.clk(clk), .rst_n(rst_n), .start(st8), .mcand(a8),
    .mplier(b8), .busy(busy8), .done(done8), .product(p8));
  booth_seq_mul #(.W(4)) dut4_i (.clk(clk), .rst_n(rst_n), .start(st4), .mcand(a4),
    .mplier(b4), .busy(busy4), .done(done4), .product(p4));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
    logic signed [15:0] xs, ys;
    xs = {{8{x[7]}}, x};
    ys = {{8{y[7]}}, y};
    return xs * ys;
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
    logic signed [7:0] xs, ys;
    xs = {{4{x[3]}}, x};
    ys = {{4{y[3]}}, y};
    return xs * ys;
  endfunction

  task automatic run8(input logic [7:0] x, input logic [7:0] y, input bit poke, input string req);
    @(negedge clk); st8 = 1'b1; a8 = x; b8 = y;
    @(negedge clk); st8 = 1'b0;
    chk(busy8 && p8 == {8'h00, y}, "R1", {busy8, p8}, {1'b1, 8'h00, y});
    if (poke) begin
      @(negedge clk); st8 = 1'b1; a8 = ~x; b8 = x ^ 8'h5a;
      @(negedge clk); st8 = 1'b0;
      repeat (5) @(negedge clk);
    end else
      repeat (7) @(negedge clk);
    chk(!done8 && busy8, "R2", {busy8, done8}, 2'b10);
    @(negedge clk);
    chk(done8 && !busy8, "R2", {busy8, done8}, 2'b01);
    chk(p8 == ref8(x, y), req, p8, ref8(x, y));
    @(negedge clk);
    chk(!done8, "R3", done8, 0);
    repeat (2) @(negedge clk);
    chk(p8 == ref8(x, y), "R9", p8, ref8(x, y));
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk); st4 = 1'b1; a4 = x; b4 = y;
    @(negedge clk); st4 = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done4 && busy4, "R2", {busy4, done4}, 2'b10);
    @(negedge clk);
    chk(done4 && !busy4 && !(busy4 && done4), "R7", {busy4, done4}, 2'b01);
    chk(p4 == ref4(x, y), (x == 4'h8 || y == 4'h8) ? "R5" : "R4", p4, ref4(x, y));
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(!busy8 && !done8 && p8 == 16'h0, "R8", {busy8, done8, p8}, 0);
    chk(!busy4 && !done4 && p4 == 8'h0, "R8", {busy4, done4, p4}, 0);
    rst_n = 1'b1;
    run8(8'h80, 8'h80, 1'b0, "R5");
    run8(8'h80, 8'h7f, 1'b0, "R5");
    run8(8'h7f, 8'h80, 1'b0, "R5");
    run8(8'hff, 8'hff, 1'b0, "R4");
    run8(8'h55, 8'haa, 1'b0, "R10");
    run8(8'h00, 8'h93, 1'b0, "R4");
    run8(8'h0b, 8'h0d, 1'b1, "R6");
    run8(8'hc3, 8'h81, 1'b1, "R6");
    for (int i = 0; i < 300; i++) begin
      logic [7:0] x, y;
      x = 8'($urandom);
      y = 8'($urandom);
      run8(x, y, 1'b0, "R4");
    end
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run4(4'(i), 4'(j));
    report();
  end
endmodule